// File: doc/BRIEF.md
# Selectable-rate one-pulse-per-second divider with arm/sync restart

The block turns a reference clock of 1, 2.5, 5 or 10 MHz into a one-pulse-per-second output. A two-bit rate code tells it which reference is present. A prescaler counts reference cycles down to a 10 ms tick. A phase counter then counts those ticks modulo 100. The output is high during the first tenth of every second, so each pulse is 100 ms wide.

The second can be re-aligned to an external event in two steps. The operator first drives the active-low arm input low while the pulse is high. The divider then stops, clears its phase and holds the output high. The next rising edge on the sync input starts a new second. Both control inputs pass through two-flop synchronizers. The restart load is shortened by the synchronizer delay, so the new second is timed from the first clock edge that samples sync high.

Tick lengths are parameters. Their defaults are the real counts for each reference. A bench or a smaller use can scale them down.

Top module: `pps_divider`

## Requirements
- R1: The rate code sets the length of one tick in clock cycles: code 2'b00 gives CYC_1M (default 10000), 2'b01 gives CYC_2M5 (default 25000), 2'b10 gives CYC_5M (default 50000) and 2'b11 gives CYC_10M (default 100000).
- R2: One output period is PHASE_MOD (100) ticks. The output is high for the first HIGH_TICKS (10) ticks and low for the remaining 90 ticks.
- R3: During reset and right after it, the divider runs with phase zero and the output high. With the reset released after clock edge C0 and tick length L, the output falls at edge C0+10·L and rises at edge C0+100·L.
- R4: The rate code is read only when a tick ends. A code change in the middle of a tick leaves that tick at its old length, and every later tick takes the new length.
- R5: An arm request (arm_n low) is taken only while the output is high. If arm_n is low while the output is low, the output continues on its normal schedule.
- R6: Once an arm request is taken, the phase is cleared and counting stops. The output stays high, with no edges, until a restart.
- R7: While stopped, a rising edge on sync_in restarts the divider. If E0 is the first clock edge that samples sync_in high, the output falls at E0+10·L and next rises at E0+100·L.
- R8: A rising edge on sync_in while the divider is running has no effect on the output.
- R9: Only a rising edge restarts a stopped divider. A sync_in level that is already high, or a falling edge, leaves it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (1, 2.5, 5 or 10 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Reference rate code, read when each tick ends |
| arm_n | input | 1 | Active-low request to stop and await sync |
| sync_in | input | 1 | External alignment event; its rising edge restarts |
| pps_out | output | 1 | One-pulse-per-second output, 10 % duty |

## Verification
The hardest state to reach is a stopped divider facing a sync level that is already high. Getting there needs an arm request placed inside the high window, and a sync rise issued earlier while the divider was still running. The stimulus raises sync during a running second and leaves it high, arms the divider at the start of the next pulse, and waits while holding sync high. It then drops sync and raises it again, and checks that the new second is timed from the clock edge that first samples the rise. Tick lengths are scaled down so that every rate code, and a rate change in the middle of a tick, fit in a short run with exact cycle counts.

// File: rtl/pps_pkg.sv
package pps_pkg;

    // Stages in the control-input synchronizer; the restart load is shortened by this.
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        RATE_1M  = 2'b00,
        RATE_2M5 = 2'b01,
        RATE_5M  = 2'b10,
        RATE_10M = 2'b11
    } rate_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } mode_e;

    typedef struct packed {
        logic arm_take;   // arm request accepted this cycle
        logic sync_rise;  // synchronized rising edge on sync
    } ctl_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pps_sync2.sv
module pps_sync2 #(
    parameter int             W       = 2,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pps_prescale.sv
module pps_prescale import pps_pkg::*; #(
    parameter int CYC_1M  = 10000,
    parameter int CYC_2M5 = 25000,
    parameter int CYC_5M  = 50000,
    parameter int CYC_10M = 100000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  restart,
    input  rate_e rate,
    output logic  tick
);
    localparam int MAXL = max4(CYC_1M, CYC_2M5, CYC_5M, CYC_10M);
    localparam int CW   = $clog2(MAXL);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_v;

    always_comb begin
        unique case (rate)
            RATE_1M:  load_v = CW'(CYC_1M  - 1);
            RATE_2M5: load_v = CW'(CYC_2M5 - 1);
            RATE_5M:  load_v = CW'(CYC_5M  - 1);
            default:  load_v = CW'(CYC_10M - 1);
        endcase
    end

    // Rate code is only consulted on reload, so a mid-tick change cannot bend a tick.
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= load_v;
        else if (restart)
            cnt <= load_v - CW'(SYNC_STAGES);
        else if (run) begin
            if (cnt == '0) cnt <= load_v;
            else           cnt <= cnt - CW'(1);
        end
    end

    assign tick = run && (cnt == '0);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(MAXL - 1));                                         // R1
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(cnt));                          // R6
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && cnt != '0) |=> cnt == $past(cnt) - CW'(1)); // R4
endmodule

// File: rtl/pps_phase.sv
module pps_phase #(
    parameter int PHASE_MOD  = 100,
    parameter int HIGH_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clear,
    output logic pulse
);
    localparam int PW = $clog2(PHASE_MOD);

    logic [PW-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst || clear)
            ph <= '0;
        else if (tick)
            ph <= (ph == PW'(PHASE_MOD - 1)) ? '0 : ph + PW'(1);
    end

    assign pulse = ph < PW'(HIGH_TICKS);

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        ph < PW'(PHASE_MOD));                                          // R2
    AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (tick && !clear && ph != PW'(PHASE_MOD - 1)) |=> ph == $past(ph) + PW'(1)); // R2
    AST_CLEAR_HIGH: assert property (@(posedge clk) disable iff (rst)
        clear |=> pulse);                                              // R6
endmodule

// File: rtl/pps_divider.sv
module pps_divider import pps_pkg::*; #(
    parameter int CYC_1M     = 10000,
    parameter int CYC_2M5    = 25000,
    parameter int CYC_5M     = 50000,
    parameter int CYC_10M    = 100000,
    parameter int PHASE_MOD  = 100,
    parameter int HIGH_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    input  logic       arm_n,
    input  logic       sync_in,
    output logic       pps_out
);
    logic [1:0] ctl_raw;
    logic [1:0] ctl_s;      // [1] arm_n, [0] sync_in, both synchronized
    logic       sync_prev;
    mode_e      mode;
    ctl_t       ctl;
    logic       tick;

    assign ctl_raw = {arm_n, sync_in};

    pps_sync2 #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    always_ff @(posedge clk) begin
        if (rst) sync_prev <= 1'b0;
        else     sync_prev <= ctl_s[0];
    end

    assign ctl.arm_take  = (mode == ST_RUN) && !ctl_s[1] && pps_out;
    assign ctl.sync_rise = ctl_s[0] && !sync_prev;

    always_ff @(posedge clk) begin
        if (rst)
            mode <= ST_RUN;
        else begin
            unique case (mode)
                ST_RUN:  if (ctl.arm_take)  mode <= ST_HALT;
                ST_HALT: if (ctl.sync_rise) mode <= ST_RUN;
                default: mode <= ST_RUN;
            endcase
        end
    end

    pps_prescale #(
        .CYC_1M (CYC_1M),
        .CYC_2M5(CYC_2M5),
        .CYC_5M (CYC_5M),
        .CYC_10M(CYC_10M)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (mode == ST_RUN),
        .restart((mode == ST_HALT) && ctl.sync_rise),
        .rate   (rate_e'(rate_sel)),
        .tick   (tick)
    );

    pps_phase #(
        .PHASE_MOD (PHASE_MOD),
        .HIGH_TICKS(HIGH_TICKS)
    ) u_ph (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .clear(ctl.arm_take),
        .pulse(pps_out)
    );

    AST_ARM_ONLY_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(mode == ST_HALT) |-> $past(pps_out));                    // R5
    AST_HALT_HOLDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_HALT) |-> pps_out);                                // R6
    AST_NO_TICK_HALTED: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_HALT) |-> !tick);                                  // R6
endmodule

// File: tb/sim_pps_divider.sv
module sim_pps_divider;
    localparam int L1 = 4, L25 = 10, L5 = 20, L10 = 40;
    localparam int MODV = 100, HIV = 10;
    localparam int LIMIT = 100000;

    typedef struct {
        logic        lvl;
        int unsigned at;
        string       tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rate_sel = 2'b11;
    logic       arm_n = 1'b1;
    logic       sync_in = 1'b0;
    logic       pps_out;

    int unsigned cyc = 0;
    int unsigned base = 0;
    int n_chk = 0, n_bad = 0;
    bit mon_on = 1'b0, done = 1'b0;
    logic prev = 1'b1;
    exp_t expq [$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    pps_divider #(
        .CYC_1M(L1), .CYC_2M5(L25), .CYC_5M(L5), .CYC_10M(L10),
        .PHASE_MOD(MODV), .HIGH_TICKS(HIV)
    ) u0 (
        .clk(clk), .rst(rst), .rate_sel(rate_sel),
        .arm_n(arm_n), .sync_in(sync_in), .pps_out(pps_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic lvl, input int unsigned at, input string tag);
        exp_t e;
        e.lvl = lvl; e.at = at; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic wait_until(input int unsigned t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: each output edge is popped against the next expected edge.
    always @(negedge clk) begin
        if (mon_on && pps_out !== prev) begin
            if (expq.size() == 0) begin
                check(1'b0, "R6/R8/R9 unexpected edge at cycle", int'(cyc), -1);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(pps_out === e.lvl, {e.tag, " edge level"}, int'(pps_out), int'(e.lvl));
                check(cyc == e.at, {e.tag, " edge cycle"}, int'(cyc), int'(e.at));
            end
            prev = pps_out;
        end
    end

    // One full second from base with tick length L.
    task automatic full_second(input int L, input string tag);
        push(1'b0, base + HIV * L, tag);
        push(1'b1, base + MODV * L, tag);
        wait_until(base + MODV * L + 1);
        base = base + MODV * L;
    endtask

    // Rate change 5 cycles into the first tick: that tick keeps the old length (R4).
    task automatic shift_rate(input logic [1:0] code, input int old_l, input int new_l);
        wait_until(base + 5);
        rate_sel = code;
        push(1'b0, base + old_l + (HIV - 1) * new_l, "R4");
        push(1'b1, base + old_l + (MODV - 1) * new_l, "R4");
        wait_until(base + old_l + (MODV - 1) * new_l + 1);
        base = base + old_l + (MODV - 1) * new_l;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(pps_out === 1'b1, "R3 output high in reset", int'(pps_out), 1);
        rst = 1'b0;
        base = cyc;
        prev = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        check(pps_out === 1'b1, "R3 output high after reset", int'(pps_out), 1);

        full_second(L10, "R3");          // code 11 from reset
        shift_rate(2'b10, L10, L5);
        full_second(L5, "R1 code10");
        shift_rate(2'b01, L5, L25);
        full_second(L25, "R1 code01");
        shift_rate(2'b00, L25, L1);
        full_second(L1, "R1 code00 R2");

        // R5: arm during the low window is ignored
        push(1'b0, base + HIV * L1, "R5");
        push(1'b1, base + MODV * L1, "R5");
        wait_until(base + 50);
        arm_n = 1'b0;
        wait_until(base + 58);
        arm_n = 1'b1;
        wait_until(base + MODV * L1 + 1);
        base = base + MODV * L1;

        // R8: sync rise while running is ignored; sync then stays high
        push(1'b0, base + HIV * L1, "R8");
        push(1'b1, base + MODV * L1, "R8");
        wait_until(base + 10);
        sync_in = 1'b1;
        wait_until(base + MODV * L1 + 1);
        base = base + MODV * L1;

        // R6: arm inside the high window halts with output high
        wait_until(base + 2);
        arm_n = 1'b0;
        wait_until(base + 12);
        arm_n = 1'b1;
        wait_until(cyc + 1000);
        check(pps_out === 1'b1, "R6 halted output high", int'(pps_out), 1);
        check(sync_in === 1'b1 && expq.size() == 0, "R9 high sync level keeps halt",
              expq.size(), 0);
        sync_in = 1'b0;
        repeat (6) @(negedge clk);
        check(pps_out === 1'b1, "R9 falling sync keeps halt", int'(pps_out), 1);

        // R7: rising sync restarts, timed from the first edge that samples it
        sync_in = 1'b1;
        base = cyc + 1;
        full_second(L1, "R7");
        full_second(L1, "R7 second after restart");
        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R7 all expected edges seen", expq.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cyc > LIMIT) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule